// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Generator

This block decides when a FIFO-mode serial transmitter should request service because its transmit queue has drained. It watches the queue occupancy, holding-register writes, interrupt-identification reads, the FIFO-mode bit and the transmit interrupt enable. From these it produces a registered pending flag and a 4-bit identification code, which the interrupt priority encoder consumes. It also produces a queue-empty indication for the line status logic.

When the queue drains after holding at most one character at a time, the empty indication is held back. The delay is the programmed frame length minus one bit, counted in per-bit ticks. The idle line then shows up only once the lone character has nearly left the shifter. Any change of the FIFO-mode bit raises the interrupt on the next cycle if FIFO mode and the enable are set.

Top module: `thre_irq_gen`

## Requirements
- R1: `pend_o` can be 1 only when `fifo_en_i` and `tx_ie_i` were both 1 at the previous clock edge. When either of them is 0, a queue-empty event leaves `pend_o` at 0, and `pend_o` drops on the next edge.
- R2: A holding-register write (`thr_wr_i`=1) makes `pend_o` 0 after the next edge, at any occupancy.
- R3: An identification read (`iir_rd_i`=1) clears `pend_o` after the next edge only when `tx_reported_i`=1. A read with `tx_reported_i`=0 leaves it set.
- R4: If occupancy reached 2 or more since the last empty event, `tx_empty_o` rises one edge after `fifo_cnt_i` becomes 0, and `pend_o` rises at the same edge.
- R5: If occupancy never reached 2 since the last empty event, `tx_empty_o` rises at the edge that takes the (`frame_bits_i`−1)th `bit_tick_i` while `fifo_cnt_i` stays 0. Counting starts at the edge after `fifo_cnt_i` becomes 0. `frame_bits_i` must be at least 2.
- R6: A nonzero `fifo_cnt_i` during the delay aborts it, and the next empty event starts the count from zero.
- R7: A change of `fifo_en_i` between two edges sets `pend_o` at the next edge when the new `fifo_en_i` and `tx_ie_i` are 1, with no empty event needed.
- R8: `iir_code_o` is 4'h2 while `pend_o`=1 and 4'h1 (bit 0 set meaning nothing pending) otherwise.
- R9: While `rst_ni`=0, `tx_empty_o`=1 and `pend_o`=0.
- R10: `tx_empty_o` is 0 after any edge at which `fifo_cnt_i` was nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| fifo_cnt_i | input | $clog2(DEPTH+1) | Transmit queue occupancy |
| thr_wr_i | input | 1 | Holding-register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| tx_reported_i | input | 1 | This source is the one the read reports |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| frame_bits_i | input | FRM_W | Bits per frame, start to last stop |
| tx_empty_o | output | 1 | Queue-empty indication, delayed when needed |
| pend_o | output | 1 | Interrupt pending |
| iir_code_o | output | 4 | Identification code for this source |

## Verification
The bench uses the default depth of 16 (5-bit occupancy) with `frame_bits_i` set to 4 for most of the run. The resulting 3-tick delay keeps the abort-and-restart case short enough to tell a restarted count from a continued one, one tick apart. It then switches to a 10-bit frame to check the 9-tick boundary, one tick before and at expiry. Occupancies of 1, 2 and 3 cover both sides of the two-character threshold.

// File: rtl/thre_pkg.sv
package thre_pkg;
  localparam logic [3:0] IIR_CODE_THRE = 4'h2;
  localparam logic [3:0] IIR_CODE_NONE = 4'h1;
endpackage

// File: rtl/thre_fill_track.sv
// Sticky flag: queue held two or more entries since the last empty event.
module thre_fill_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             empty_set_i,
  output logic             seen2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       seen2_o <= 1'b0;
    else if (fifo_cnt_i >= CNT_W'(2))  seen2_o <= 1'b1;
    else if (empty_set_i)              seen2_o <= 1'b0;
  end
endmodule

// File: rtl/thre_empty_dly.sv
module thre_empty_dly #(
  parameter int CNT_W = 5,
  parameter int FRM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             seen2_i,
  input  logic             bit_tick_i,
  input  logic [FRM_W-1:0] frame_bits_i,
  output logic             empty_o,
  output logic             empty_set_o
);
  logic             dly_act_q;
  logic [FRM_W-1:0] dly_cnt_q;
  logic [FRM_W-1:0] dly_term;
  logic             nz;
  logic             dly_done;

  always_comb begin
    nz          = (fifo_cnt_i != '0);
    dly_term    = frame_bits_i - 1'b1;
    dly_done    = dly_act_q && bit_tick_i && ((dly_cnt_q + 1'b1) == dly_term);
    empty_set_o = !nz && !empty_o && ((!dly_act_q && seen2_i) || dly_done);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o   <= 1'b1;
      dly_act_q <= 1'b0;
      dly_cnt_q <= '0;
    end else if (nz) begin
      // any occupancy aborts a running delay
      empty_o   <= 1'b0;
      dly_act_q <= 1'b0;
      dly_cnt_q <= '0;
    end else if (empty_set_o) begin
      empty_o   <= 1'b1;
      dly_act_q <= 1'b0;
      dly_cnt_q <= '0;
    end else if (!empty_o && !dly_act_q) begin
      dly_act_q <= 1'b1;
      dly_cnt_q <= '0;
    end else if (dly_act_q && bit_tick_i) begin
      dly_cnt_q <= dly_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/thre_pend.sv
module thre_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_set_i,
  input  logic fifo_en_i,
  input  logic tx_ie_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic tx_reported_i,
  output logic pend_o
);
  logic fifo_en_q;
  logic en_chg, set, clr;

  always_comb begin
    en_chg = fifo_en_i ^ fifo_en_q;
    set    = empty_set_i | en_chg;
    clr    = thr_wr_i | (iir_rd_i & tx_reported_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      pend_o    <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en_i;
      pend_o    <= (pend_o | set) & ~clr & fifo_en_i & tx_ie_i;
    end
  end
endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen
  import thre_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FRM_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             tx_ie_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             tx_reported_i,
  input  logic             bit_tick_i,
  input  logic [FRM_W-1:0] frame_bits_i,
  output logic             tx_empty_o,
  output logic             pend_o,
  output logic [3:0]       iir_code_o
);
  logic seen2, empty_set;

  thre_fill_track #(.CNT_W(CNT_W)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_cnt_i  (fifo_cnt_i),
    .empty_set_i (empty_set),
    .seen2_o     (seen2)
  );

  thre_empty_dly #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_dly (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_cnt_i   (fifo_cnt_i),
    .seen2_i      (seen2),
    .bit_tick_i   (bit_tick_i),
    .frame_bits_i (frame_bits_i),
    .empty_o      (tx_empty_o),
    .empty_set_o  (empty_set)
  );

  thre_pend u_pend (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .empty_set_i   (empty_set),
    .fifo_en_i     (fifo_en_i),
    .tx_ie_i       (tx_ie_i),
    .thr_wr_i      (thr_wr_i),
    .iir_rd_i      (iir_rd_i),
    .tx_reported_i (tx_reported_i),
    .pend_o        (pend_o)
  );

  assign iir_code_o = pend_o ? IIR_CODE_THRE : IIR_CODE_NONE;
endmodule

// File: rtl/thre_irq_gen_chk.sv
module thre_irq_gen_chk #(
  parameter int DEPTH = 16,
  parameter int FRM_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             tx_ie_i,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic             thr_wr_i,
  input logic             iir_rd_i,
  input logic             tx_reported_i,
  input logic             bit_tick_i,
  input logic [FRM_W-1:0] frame_bits_i,
  input logic             tx_empty_o,
  input logic             pend_o,
  input logic [3:0]       iir_code_o
);
  AST_PEND_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> $past(fifo_en_i && tx_ie_i)); // R1
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !pend_o); // R2
  AST_IIR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && tx_reported_i) |=> !pend_o); // R3
  AST_EMPTY_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(fifo_cnt_i == '0)); // R5
  AST_NONZERO_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i != '0) |=> !tx_empty_o); // R10
endmodule

bind thre_irq_gen thre_irq_gen_chk #(.DEPTH(DEPTH), .FRM_W(FRM_W)) u_chk (.*);

// File: tb/thre_irq_gen_test.sv
module thre_irq_gen_test;
  localparam int PERIOD = 10;
  localparam int NVEC = 20;
  // {cnt[4:0], wr, rd, rep, tick, exp_empty, exp_pend}
  localparam logic [10:0] VEC [NVEC] = '{
    {5'd1, 4'b1000, 2'b00},  // R10 one byte in
    {5'd0, 4'b0000, 2'b00},  // R5 delay starts
    {5'd0, 4'b0001, 2'b00},
    {5'd0, 4'b0001, 2'b00},
    {5'd0, 4'b0000, 2'b00},
    {5'd0, 4'b0001, 2'b11},  // R5 third tick
    {5'd0, 4'b1000, 2'b10},  // R2 write clears
    {5'd2, 4'b0000, 2'b00},  // R4 two held
    {5'd1, 4'b0000, 2'b00},
    {5'd0, 4'b0000, 2'b11},  // R4 immediate
    {5'd0, 4'b0100, 2'b11},  // R3 other source reported
    {5'd0, 4'b0110, 2'b10},  // R3 clear
    {5'd1, 4'b1000, 2'b00},
    {5'd0, 4'b0000, 2'b00},
    {5'd0, 4'b0001, 2'b00},
    {5'd1, 4'b1000, 2'b00},  // R6 abort
    {5'd0, 4'b0000, 2'b00},
    {5'd0, 4'b0001, 2'b00},
    {5'd0, 4'b0001, 2'b00},  // R6 restarted count
    {5'd0, 4'b0001, 2'b11}
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0, tx_ie_i = 1'b0;
  logic [4:0] fifo_cnt_i = '0;
  logic       thr_wr_i = 1'b0, iir_rd_i = 1'b0, tx_reported_i = 1'b0, bit_tick_i = 1'b0;
  logic [3:0] frame_bits_i = 4'd4;
  logic       tx_empty_o, pend_o;
  logic [3:0] iir_code_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  thre_irq_gen uut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [4:0] c, input logic w, input logic r,
                     input logic p, input logic t);
    fifo_cnt_i = c; thr_wr_i = w; iir_rd_i = r; tx_reported_i = p; bit_tick_i = t;
    @(negedge clk_i);
    thr_wr_i = 0; iir_rd_i = 0; tx_reported_i = 0; bit_tick_i = 0;
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD*2);
    chk("R9 empty in reset", {3'b0, tx_empty_o}, 4'd1);
    chk("R9 pend in reset", {3'b0, pend_o}, 4'd0);
    chk("R8 code idle", iir_code_o, 4'h1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    fifo_en_i = 1'b1; tx_ie_i = 1'b1;
    @(negedge clk_i);
    chk("R7 enable change raises pend", {3'b0, pend_o}, 4'd1);
    chk("R8 code pending", iir_code_o, 4'h2);
    cyc(0, 0, 1, 1, 0);
    chk("R3 read clears", {3'b0, pend_o}, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][10:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("vec%0d empty R4/R5/R6/R10", i), {3'b0, tx_empty_o}, {3'b0, VEC[i][1]});
      chk($sformatf("vec%0d pend R1/R2/R3", i), {3'b0, pend_o}, {3'b0, VEC[i][0]});
    end

    // R1: disabled source stays quiet on an empty event
    cyc(0, 0, 1, 1, 0);
    tx_ie_i = 1'b0;
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 1);
    chk("R1 empty without enable", {3'b0, tx_empty_o}, 4'd1);
    chk("R1 no pend without enable", {3'b0, pend_o}, 4'd0);
    tx_ie_i = 1'b1;
    cyc(0, 0, 0, 0, 0);
    chk("R1 enable alone does not raise", {3'b0, pend_o}, 4'd0);

    // R7: toggling the FIFO mode bit
    fifo_en_i = 1'b0;
    cyc(0, 0, 0, 0, 0);
    chk("R7 disabled mode no pend", {3'b0, pend_o}, 4'd0);
    fifo_en_i = 1'b1;
    cyc(0, 0, 0, 0, 0);
    chk("R7 re-enable raises pend", {3'b0, pend_o}, 4'd1);
    tx_ie_i = 1'b0;
    cyc(0, 0, 0, 0, 0);
    chk("R1 pend drops with enable low", {3'b0, pend_o}, 4'd0);
    tx_ie_i = 1'b1;

    // R5: 10-bit frame, 9 ticks
    frame_bits_i = 4'd10;
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 1);
    chk("R5 not empty after 8 ticks", {3'b0, tx_empty_o}, 4'd0);
    cyc(0, 0, 0, 0, 1);
    chk("R5 empty after 9 ticks", {3'b0, tx_empty_o}, 4'd1);
    chk("R5 pend with delayed empty", {3'b0, pend_o}, 4'd1);
    chk("R8 code pending", iir_code_o, 4'h2);

    // R2 at higher occupancy, then R9 asynchronous reset
    cyc(3, 1, 0, 0, 0);
    chk("R2 write clears", {3'b0, pend_o}, 4'd0);
    chk("R10 occupied", {3'b0, tx_empty_o}, 4'd0);
    #1 rst_ni = 1'b0;
    #1;
    chk("R9 reset empty", {3'b0, tx_empty_o}, 4'd1);
    chk("R9 reset pend", {3'b0, pend_o}, 4'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule